// File: doc/BRIEF.md
# SPI Slave Character Engine

This block is the receive and transmit core of an SPI target device. It watches the serial clock, the select line and the data-in line of an external controller, shifts one character of 1 to 8 bits per frame and hands the received character to the host side right-aligned. At the same time it sends the host's transmit byte, most significant bit first. All pins are brought into the system clock domain through two-flop synchronisers, so the system clock must run at no less than four times the serial clock.

Characters may follow one another without the select line being released. Every completed character raises the interrupt status. If the select line is released partway through a character, an abort error is raised together with the interrupt, and the bit pointer returns to the start, so the next frame begins again at transmit bit 7. The host clears the interrupt and the abort error through separate write-one strobes, and can raise the interrupt on its own with a start strobe.

Top module: `spi_char_slave`

## Requirements
- R1: After reset, irq_stat, irq_req and abt_err are 0, rx_data is 0x00, miso_oe is 0 and miso_out is 0.
- R2: char_len selects the character length: values 1 to 7 give that many bits, value 0 gives 8 bits.
- R3: Bits move MSB first. The transmitted bits are tx_data[7] downward, one per bit of the character. The received character sits in the low char_len bits of rx_data with all higher bits 0.
- R4: With cpha=0, MOSI is sampled on the leading SCK edge; with cpha=1, on the trailing edge. The leading edge is the rising edge when cpol=0 and the falling edge when cpol=1.
- R5: Completing a character sets irq_stat, and irq_req follows irq_stat.
- R6: Several characters may be transferred within one select assertion. Each one updates rx_data and sets irq_stat, and each one starts its transmit bits again at tx_data[7].
- R7: Releasing ss_n with a character partly transferred sets abt_err and irq_stat and leaves rx_data unchanged.
- R8: On the first select assertion after an abort, miso_out presents tx_data[7] before any SCK edge, and the whole character is sent from bit 7 down.
- R9: A pulse on wr_irq_clr clears irq_stat, and a pulse on wr_abt_clr clears abt_err. Each strobe leaves the other flag alone.
- R10: A pulse on wr_start sets irq_stat.
- R11: An SCK edge is acted on at the third rising system-clock edge after it reaches the pin. If a set event falls in the same cycle as a clear strobe for the same flag, the flag ends up set.
- R12: miso_oe is 1 exactly while the synchronised ss_n is low. While miso_oe is 0, miso_out is 0.
- R13: Releasing ss_n when no bit of a character is in progress does not set abt_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_in | input | 1 | Serial clock from the controller |
| ss_n_in | input | 1 | Active-low target select |
| mosi_in | input | 1 | Serial data from the controller |
| char_len | input | 3 | Character length, 0 meaning 8 bits |
| cpol | input | 1 | Idle level of SCK |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| tx_data | input | 8 | Byte to transmit |
| wr_irq_clr | input | 1 | Write-one strobe that clears irq_stat |
| wr_abt_clr | input | 1 | Write-one strobe that clears abt_err |
| wr_start | input | 1 | Write-one strobe that forces irq_stat |
| miso_out | output | 1 | Serial data to the controller |
| miso_oe | output | 1 | Output enable for the MISO pad |
| rx_data | output | 8 | Last complete received character, right-aligned |
| irq_stat | output | 1 | Interrupt pending status |
| abt_err | output | 1 | Abort error flag |
| irq_req | output | 1 | Interrupt request line |

## Verification
The risky overlap is a character completing in the same system cycle in which software writes the interrupt-clear strobe. The bench sends a one-bit character and places the clear pulse on the third rising clock edge after the sampling SCK edge reaches the pin, which is the cycle the completion is recorded. It then expects irq_stat to stay set. A second clear one cycle later must then drop the flag, which shows that the first clear really did meet the completion and was not simply early or late.

// File: rtl/spi_char_pkg.sv
// Shared types and helpers for the SPI slave character engine.
// Assumes 1-bit pin events derived in the system clock domain.
package spi_char_pkg;

    // Synchronised level of one pin plus its edge events for the current cycle
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } pin_evt_t;

    // Picks the SCK edge that samples MOSI for a given polarity/phase
    function automatic logic sample_edge(input logic pol, input logic pha, input pin_evt_t sck);
        logic lead;
        logic trail;
        lead  = pol ? sck.fall : sck.rise;
        trail = pol ? sck.rise : sck.fall;
        return pha ? trail : lead;
    endfunction

endpackage

// File: rtl/spi_sync_edge.sv
// Multi-flop synchroniser with edge detection for one asynchronous pin.
// Assumes the pin is stable for at least two system clocks between changes.
module spi_sync_edge
    import spi_char_pkg::*;
#(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin,
    output pin_evt_t evt
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the pin through the synchroniser chain and keep the last level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    // Derive level and edge events from the synchronised samples
    always_comb begin
        evt.lvl  = chain_q[STAGES-1];
        evt.rise = chain_q[STAGES-1] & ~prev_q;
        evt.fall = ~chain_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/spi_shift_core.sv
// Bit counter and shift register for one character of 1..DW bits.
// Assumes sample events are single-cycle pulses, and that char_len is held
// steady while a character is in progress.
module spi_shift_core #(
    parameter int DW = 8,
    parameter int LW = $clog2(DW),
    parameter int CW = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          desel_evt,
    input  logic          smp_evt,
    input  logic          mosi,
    input  logic [LW-1:0] char_len,
    input  logic [DW-1:0] tx_data,
    output logic          miso_bit,
    output logic [DW-1:0] rx_data,
    output logic          char_done,
    output logic          abort_evt,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] nbits
);

    logic [DW-1:0] sh_q;
    logic [DW-1:0] sh_next;
    logic [DW-1:0] mask;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] rx_q;
    logic [CW-1:0] last;
    logic [LW-1:0] idx;

    // Decode the character length and the mask that right-aligns the data
    always_comb begin
        nbits = (char_len == '0) ? CW'(DW) : {1'b0, char_len};
        last  = nbits - CW'(1);
        for (int i = 0; i < DW; i++) begin
            mask[i] = (i < int'(nbits));
        end
    end

    // Form the next shift value and the event strobes
    always_comb begin
        sh_next   = {sh_q[DW-2:0], mosi};
        char_done = sel && smp_evt && (cnt_q == last);
        abort_evt = desel_evt && (cnt_q != '0);
        idx       = LW'(DW - 1) - cnt_q[LW-1:0];
        miso_bit  = tx_data[idx];
    end

    // Advance the bit pointer, shift data and latch completed characters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
            rx_q  <= '0;
        end else if (desel_evt) begin
            cnt_q <= '0;
        end else if (sel && smp_evt) begin
            sh_q <= sh_next;
            if (cnt_q == last) begin
                cnt_q <= '0;
                rx_q  <= sh_next & mask;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign rx_data = rx_q;
    assign cnt     = cnt_q;

endmodule

// File: rtl/spi_irq_flags.sv
// Interrupt status and abort error flags with write-one-to-clear strobes.
// Assumes that a set event in the same cycle as a clear strobe wins.
module spi_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic char_done,
    input  logic abort_evt,
    input  logic wr_start,
    input  logic wr_irq_clr,
    input  logic wr_abt_clr,
    output logic irq_stat,
    output logic abt_err
);

    logic irq_q;
    logic abt_q;

    // Hold the interrupt status: set events take priority over the clear strobe
    always_ff @(posedge clk) begin
        if (!rst_n)                              irq_q <= 1'b0;
        else if (char_done || abort_evt || wr_start) irq_q <= 1'b1;
        else if (wr_irq_clr)                     irq_q <= 1'b0;
    end

    // Hold the abort error: an abort takes priority over the clear strobe
    always_ff @(posedge clk) begin
        if (!rst_n)          abt_q <= 1'b0;
        else if (abort_evt)  abt_q <= 1'b1;
        else if (wr_abt_clr) abt_q <= 1'b0;
    end

    assign irq_stat = irq_q;
    assign abt_err  = abt_q;

endmodule

// File: rtl/spi_char_slave.sv
// Top of the SPI slave character engine: synchronises SCK, SS and MOSI,
// selects the sampling edge, shifts characters and raises interrupt flags.
// Assumes the system clock runs at no less than 4x SCK.
module spi_char_slave
    import spi_char_pkg::*;
#(
    parameter int DW     = 8,
    parameter int SYNC_N = 2,
    parameter int LW     = $clog2(DW),
    parameter int CW     = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_in,
    input  logic          ss_n_in,
    input  logic          mosi_in,
    input  logic [LW-1:0] char_len,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [DW-1:0] tx_data,
    input  logic          wr_irq_clr,
    input  logic          wr_abt_clr,
    input  logic          wr_start,
    output logic          miso_out,
    output logic          miso_oe,
    output logic [DW-1:0] rx_data,
    output logic          irq_stat,
    output logic          abt_err,
    output logic          irq_req
);

    localparam int          NPIN    = 3;
    localparam logic [NPIN-1:0] RST_VEC = 3'b010;   // select line idles high

    logic [NPIN-1:0] pins;
    pin_evt_t        evts [NPIN];
    logic            sel;
    logic            smp_evt;
    logic            miso_bit;
    logic            char_done;
    logic            abort_evt;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   nbits;

    assign pins = {mosi_in, ss_n_in, sck_in};

    // One synchroniser per pin: index 0 SCK, 1 SS, 2 MOSI
    for (genvar gi = 0; gi < NPIN; gi++) begin : g_sync
        spi_sync_edge #(
            .STAGES  (SYNC_N),
            .RST_VAL (RST_VEC[gi])
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pins[gi]),
            .evt   (evts[gi])
        );
    end

    // Resolve select level and the sampling edge for the configured mode
    always_comb begin
        sel     = ~evts[1].lvl;
        smp_evt = sample_edge(cpol, cpha, evts[0]);
    end

    spi_shift_core #(
        .DW (DW),
        .LW (LW),
        .CW (CW)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .desel_evt (evts[1].rise),
        .smp_evt   (smp_evt),
        .mosi      (evts[2].lvl),
        .char_len  (char_len),
        .tx_data   (tx_data),
        .miso_bit  (miso_bit),
        .rx_data   (rx_data),
        .char_done (char_done),
        .abort_evt (abort_evt),
        .cnt       (cnt),
        .nbits     (nbits)
    );

    spi_irq_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_done  (char_done),
        .abort_evt  (abort_evt),
        .wr_start   (wr_start),
        .wr_irq_clr (wr_irq_clr),
        .wr_abt_clr (wr_abt_clr),
        .irq_stat   (irq_stat),
        .abt_err    (abt_err)
    );

    // Drive MISO only while selected; drive it low otherwise
    always_comb begin
        miso_oe  = sel;
        miso_out = sel & miso_bit;
        irq_req  = irq_stat;
    end

endmodule

// File: rtl/spi_char_chk.sv
// Property checker for the SPI slave character engine, bound to the top.
module spi_char_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_irq_clr,
    input logic          wr_abt_clr,
    input logic          wr_start,
    input logic          char_done,
    input logic          abort_evt,
    input logic          irq_stat,
    input logic          abt_err,
    input logic          miso_oe,
    input logic          miso_out,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] nbits
);

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < nbits);

    // R5
    done_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> irq_stat);

    // R7
    abort_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> (abt_err && irq_stat));

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_irq_clr && !char_done && !abort_evt && !wr_start) |=> !irq_stat);

    // R9
    abt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_abt_clr && !abort_evt) |=> !abt_err);

    // R10
    start_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> irq_stat);

    // R11
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_irq_clr && char_done) |=> irq_stat);

    // R12
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |-> !miso_out);

endmodule

bind spi_char_slave spi_char_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_irq_clr (wr_irq_clr),
    .wr_abt_clr (wr_abt_clr),
    .wr_start   (wr_start),
    .char_done  (char_done),
    .abort_evt  (abort_evt),
    .irq_stat   (irq_stat),
    .abt_err    (abt_err),
    .miso_oe    (miso_oe),
    .miso_out   (miso_out),
    .cnt        (cnt),
    .nbits      (nbits)
);

// File: tb/sim_spi_char_slave.sv
// Directed bench for spi_char_slave: one task per scenario, each self-checking.
module sim_spi_char_slave;

    localparam int HALF = 8;   // system clocks per SCK half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_in = 1'b0;
    logic       ss_n_in = 1'b1;
    logic       mosi_in = 1'b0;
    logic [2:0] char_len = 3'd0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       wr_irq_clr = 1'b0;
    logic       wr_abt_clr = 1'b0;
    logic       wr_start = 1'b0;
    logic       miso_out;
    logic       miso_oe;
    logic [7:0] rx_data;
    logic       irq_stat;
    logic       abt_err;
    logic       irq_req;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    spi_char_slave u0 (
        .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .ss_n_in(ss_n_in),
        .mosi_in(mosi_in), .char_len(char_len), .cpol(cpol), .cpha(cpha),
        .tx_data(tx_data), .wr_irq_clr(wr_irq_clr), .wr_abt_clr(wr_abt_clr),
        .wr_start(wr_start), .miso_out(miso_out), .miso_oe(miso_oe),
        .rx_data(rx_data), .irq_stat(irq_stat), .abt_err(abt_err),
        .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        wait_clk(1);
        s = 1'b0;
        wait_clk(1);
    endtask

    task automatic ss_on();
        sck_in = cpol;
        wait_clk(HALF);
        ss_n_in = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic ss_off();
        ss_n_in = 1'b1;
        wait_clk(HALF);
    endtask

    // Controller model: shifts n bits of val (MSB first), collects MISO bits
    task automatic shift_bits(input int n, input logic [7:0] val, output logic [7:0] got);
        got = 8'h00;
        for (int i = n - 1; i >= 0; i--) begin
            if (!cpha) begin
                mosi_in = val[i];
                wait_clk(HALF);
                got[i] = miso_out;
                sck_in = ~sck_in;
                wait_clk(HALF);
                sck_in = ~sck_in;
            end else begin
                sck_in = ~sck_in;
                mosi_in = val[i];
                wait_clk(HALF);
                got[i] = miso_out;
                sck_in = ~sck_in;
                wait_clk(HALF);
            end
        end
        wait_clk(HALF);
    endtask

    task automatic t_reset();
        check("R1 irq_stat", irq_stat, 0);
        check("R1 irq_req", irq_req, 0);
        check("R1 abt_err", abt_err, 0);
        check("R1 rx_data", rx_data, 0);
        check("R1 miso_oe", miso_oe, 0);
        check("R12 miso idle", miso_out, 0);
    endtask

    task automatic t_mode0_full();
        logic [7:0] got;
        cpol = 0; cpha = 0; char_len = 3'd0; tx_data = 8'h3C;
        ss_on();
        check("R12 oe on select", miso_oe, 1);
        shift_bits(8, 8'hA5, got);
        check("R3 tx bits mode0", got, 8'h3C);
        check("R2 R4 rx 8-bit", rx_data, 8'hA5);
        check("R5 irq_stat", irq_stat, 1);
        check("R5 irq_req", irq_req, 1);
        ss_off();
        check("R13 no abort", abt_err, 0);
        check("R12 oe off", miso_oe, 0);
        pulse(wr_irq_clr);
        check("R9 irq clear", irq_stat, 0);
    endtask

    task automatic t_mode3_short();
        logic [7:0] got;
        cpol = 1; cpha = 1; char_len = 3'd3; tx_data = 8'hA0;
        ss_on();
        shift_bits(3, 8'h06, got);
        check("R3 tx bits 3-bit", got, 8'h05);
        check("R3 R4 rx right-aligned", rx_data, 8'h06);
        ss_off();
        check("R13 no abort short", abt_err, 0);
        pulse(wr_irq_clr);
    endtask

    task automatic t_back_to_back();
        logic [7:0] got;
        cpol = 0; cpha = 1; char_len = 3'd4; tx_data = 8'h90;
        ss_on();
        shift_bits(4, 8'h0C, got);
        check("R6 first rx", rx_data, 8'h0C);
        check("R6 first irq", irq_stat, 1);
        pulse(wr_irq_clr);
        check("R9 clear between", irq_stat, 0);
        shift_bits(4, 8'h03, got);
        check("R6 second tx restart", got, 8'h09);
        check("R6 second rx", rx_data, 8'h03);
        check("R6 second irq", irq_stat, 1);
        ss_off();
        pulse(wr_irq_clr);
    endtask

    task automatic t_abort();
        logic [7:0] got;
        cpol = 0; cpha = 0; char_len = 3'd0; tx_data = 8'hB4;
        ss_on();
        shift_bits(3, 8'h07, got);
        check("R3 partial tx", got, 8'h05);
        ss_off();
        check("R7 abt_err", abt_err, 1);
        check("R7 irq_stat", irq_stat, 1);
        check("R7 rx kept", rx_data, 8'h03);
        pulse(wr_abt_clr);
        check("R9 abt cleared", abt_err, 0);
        check("R9 irq untouched", irq_stat, 1);
        pulse(wr_irq_clr);
        check("R9 abt untouched", abt_err, 0);
        ss_on();
        check("R8 first bit", miso_out, 1);
        shift_bits(8, 8'h5A, got);
        check("R8 full restart", got, 8'hB4);
        check("R8 rx after restart", rx_data, 8'h5A);
        ss_off();
        pulse(wr_irq_clr);
    endtask

    task automatic t_start();
        check("R10 pre", irq_stat, 0);
        pulse(wr_start);
        check("R10 start sets", irq_stat, 1);
        pulse(wr_irq_clr);
        check("R9 after start", irq_stat, 0);
    endtask

    // Completion and clear land on the same rising clock edge
    task automatic t_collide();
        cpol = 0; cpha = 0; char_len = 3'd1; tx_data = 8'h80;
        ss_on();
        mosi_in = 1'b1;
        wait_clk(HALF);
        sck_in = 1'b1;          // sampling edge at pin
        wait_clk(2);            // two synchroniser edges have passed
        wr_irq_clr = 1'b1;      // covers the third edge: completion cycle
        wait_clk(1);
        wr_irq_clr = 1'b0;
        wait_clk(1);
        check("R11 set wins", irq_stat, 1);
        check("R11 rx 1-bit", rx_data, 8'h01);
        pulse(wr_irq_clr);
        check("R11 later clear", irq_stat, 0);
        wait_clk(HALF);
        sck_in = 1'b0;
        wait_clk(HALF);
        ss_off();
        check("R13 no abort 1-bit", abt_err, 0);
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_mode0_full();
        t_mode3_short();
        t_back_to_back();
        t_abort();
        t_start();
        t_collide();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule